// File: doc/BRIEF.md
# Transmit undershoot-guard pattern generator

This block produces a one-bit guard drive that shapes the transmit modulation during a sub-carrier cycle, so that the antenna driver does not undershoot. At the start of each sub-carrier cycle a strobe arrives. If the block is armed, it plays out a programmable pattern one bit per clock. The pattern is taken from a 16-bit pattern word, starting at its most significant bit. The number of bits played is the 4-bit length field plus one.

Two mode enables choose when the guard is applied. The all-cycles enable arms the guard on every sub-carrier cycle while modulation is active. The final-cycle enable arms it only on the last sub-carrier cycle of a card-mode transmission, which the last-cycle indicator flags. The two enables must not be set together. If they are, the block raises a configuration error and keeps the guard low.

The configuration inputs are registered once inside the block. A setting takes effect from the clock edge after the edge that samples it. The pattern and the length are copied into the sequencer when a sequence starts.

Top module: `tx_guard_gen`

## Requirements
- R1: After reset, `guard_o` and `cfg_err_o` are 0, and the registered enables, length and pattern are 0.
- R2: A started sequence drives `guard_o` for exactly len+1 clock cycles, where len is the registered 4-bit length (1 to 16 cycles). After that `guard_o` stays 0 until the next start.
- R3: Output cycle i of a sequence (i = 0 in the cycle after the start edge) carries bit 15-i of the pattern, so the most significant bit comes first.
- R4: Pattern bits below bit 15-len have no effect on `guard_o`.
- R5: With only the all-cycles enable set, a strobe with `mod_active_i`=1 starts a sequence, whatever the value of `last_cyc_i`.
- R6: With only the final-cycle enable set, a strobe starts a sequence only when `last_cyc_i`=1 and `mod_active_i`=1. Otherwise `guard_o` stays 0.
- R7: When both registered enables are 1, `cfg_err_o` is 1, no sequence starts and `guard_o` is 0.
- R8: A strobe with `mod_active_i`=0 starts no sequence.
- R9: A qualifying strobe during a running sequence restarts it from the most significant pattern bit, using the current configuration.
- R10: Configuration inputs take effect one clock after they are sampled. Changing the pattern or the length while a sequence runs does not alter that sequence.
- R11: Clearing both enables while a sequence runs forces `guard_o` to 0 in the next cycle and ends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_strobe_i | input | 1 | One-clock pulse at the start of a sub-carrier cycle |
| last_cyc_i | input | 1 | The current sub-carrier cycle is the last one of a card-mode transmission |
| mod_active_i | input | 1 | Transmit modulation is active |
| pattern_i | input | 16 | Guard pattern, played out starting at the most significant bit |
| len_i | input | 4 | Pattern length minus one |
| en_all_i | input | 1 | Arms the guard on every sub-carrier cycle |
| en_last_i | input | 1 | Arms the guard on the last sub-carrier cycle only |
| guard_o | output | 1 | Guard drive bit |
| cfg_err_o | output | 1 | Both enables are set (illegal configuration) |

## Verification
The hardest situation to reach is a strobe that lands in the middle of a running sequence. The same holds for a configuration change during a sequence: it must be ignored for the pattern and length, but acted on at once when both enables are cleared. The bench starts a full-length sequence and samples a few bits. In the same falling-edge slot as a sample it then pulses the strobe again, changes the pattern, or drops the enables. This lands each event on a known bit index, so the restart point, the captured pattern and the forced low can each be checked at an exact cycle.

// File: rtl/tx_guard_pkg.sv
package tx_guard_pkg;
  parameter int unsigned PAT_W_DEF = 16;
  parameter int unsigned LEN_W_DEF = 4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ALL  = 2'b01,
    MODE_LAST = 2'b10,
    MODE_BAD  = 2'b11
  } guard_mode_e;
endpackage

// File: rtl/tx_guard_cfg_reg.sv
module tx_guard_cfg_reg #(
  parameter int unsigned PAT_W = 16,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             en_all_i,
  input  logic             en_last_i,
  output logic [PAT_W-1:0] pattern_q_o,
  output logic [LEN_W-1:0] len_q_o,
  output logic             en_all_q_o,
  output logic             en_last_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pattern_q_o <= '0;
      len_q_o     <= '0;
      en_all_q_o  <= 1'b0;
      en_last_q_o <= 1'b0;
    end else begin
      pattern_q_o <= pattern_i;
      len_q_o     <= len_i;
      en_all_q_o  <= en_all_i;
      en_last_q_o <= en_last_i;
    end
  end
endmodule

// File: rtl/tx_guard_arbiter.sv
module tx_guard_arbiter
  import tx_guard_pkg::*;
(
  input  logic        cyc_strobe_i,
  input  logic        last_cyc_i,
  input  logic        mod_active_i,
  input  logic        en_all_q_i,
  input  logic        en_last_q_i,
  output guard_mode_e mode_o,
  output logic        start_o,
  output logic        abort_o,
  output logic        err_o
);
  always_comb begin
    mode_o = guard_mode_e'({en_last_q_i, en_all_q_i});
    start_o = 1'b0;
    abort_o = 1'b0;
    err_o   = 1'b0;
    unique case (mode_o)
      MODE_OFF:  abort_o = 1'b1;
      MODE_ALL:  start_o = cyc_strobe_i & mod_active_i;
      MODE_LAST: start_o = cyc_strobe_i & mod_active_i & last_cyc_i;
      MODE_BAD: begin
        abort_o = 1'b1;
        err_o   = 1'b1;
      end
      default: abort_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tx_guard_shifter.sv
module tx_guard_shifter #(
  parameter int unsigned PAT_W = 16,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             bit_o
);
  localparam int unsigned CNT_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_cnt;

  // length field plus one, clipped to the pattern width
  always_comb begin
    if ((32'(len_i) + 32'd1) > 32'(PAT_W)) load_cnt = CNT_W'(PAT_W);
    else                                   load_cnt = CNT_W'(len_i) + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (abort_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      sh_q  <= pattern_i;
      cnt_q <= load_cnt;
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[PAT_W-2:0], 1'b0};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign bit_o  = busy_o & sh_q[PAT_W-1];
endmodule

// File: rtl/tx_guard_gen.sv
module tx_guard_gen
  import tx_guard_pkg::*;
#(
  parameter int unsigned PAT_W = PAT_W_DEF,
  parameter int unsigned LEN_W = LEN_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_strobe_i,
  input  logic             last_cyc_i,
  input  logic             mod_active_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             en_all_i,
  input  logic             en_last_i,
  output logic             guard_o,
  output logic             cfg_err_o
);
  logic [PAT_W-1:0] pattern_q;
  logic [LEN_W-1:0] len_q;
  logic             en_all_q, en_last_q;
  guard_mode_e      mode;
  logic             start, abort, err;
  logic             busy, seq_bit;

  tx_guard_cfg_reg #(.PAT_W(PAT_W), .LEN_W(LEN_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pattern_i   (pattern_i),
    .len_i       (len_i),
    .en_all_i    (en_all_i),
    .en_last_i   (en_last_i),
    .pattern_q_o (pattern_q),
    .len_q_o     (len_q),
    .en_all_q_o  (en_all_q),
    .en_last_q_o (en_last_q)
  );

  tx_guard_arbiter i_arb (
    .cyc_strobe_i (cyc_strobe_i),
    .last_cyc_i   (last_cyc_i),
    .mod_active_i (mod_active_i),
    .en_all_q_i   (en_all_q),
    .en_last_q_i  (en_last_q),
    .mode_o       (mode),
    .start_o      (start),
    .abort_o      (abort),
    .err_o        (err)
  );

  tx_guard_shifter #(.PAT_W(PAT_W), .LEN_W(LEN_W)) i_shf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .abort_i   (abort),
    .pattern_i (pattern_q),
    .len_i     (len_q),
    .busy_o    (busy),
    .bit_o     (seq_bit)
  );

  // disabled or illegal mode masks the drive at once
  assign guard_o   = seq_bit & ~abort;
  assign cfg_err_o = err;
endmodule

// File: rtl/tx_guard_chk.sv
module tx_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_strobe_i,
  input logic last_cyc_i,
  input logic mod_active_i,
  input logic en_all_i,
  input logic en_last_i,
  input logic en_all_q,
  input logic en_last_q,
  input logic busy,
  input logic guard_o,
  input logic cfg_err_o
);
  p_err_masks_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !guard_o);

  p_err_from_inputs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> ($past(en_all_i) && $past(en_last_i)));

  p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !guard_o);

  p_no_mod_no_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_strobe_i && !mod_active_i && !busy) |=> !guard_o);

  p_last_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_last_q && !en_all_q && cyc_strobe_i && !last_cyc_i && !busy) |=> !guard_o);

  p_disabled_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_all_q && !en_last_q) |-> !guard_o);

  always_comb begin
    if (!rst_ni) a_reset_r1: assert (!guard_o && !cfg_err_o);
  end
endmodule

bind tx_guard_gen tx_guard_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_strobe_i (cyc_strobe_i),
  .last_cyc_i   (last_cyc_i),
  .mod_active_i (mod_active_i),
  .en_all_i     (en_all_i),
  .en_last_i    (en_last_i),
  .en_all_q     (en_all_q),
  .en_last_q    (en_last_q),
  .busy         (busy),
  .guard_o      (guard_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/test_tx_guard_gen.sv
module test_tx_guard_gen;
  localparam int CLK_P = 10;
  localparam int N_VEC = 6;
  localparam logic [19:0] VEC [N_VEC] = '{
    {16'hA5C3, 4'd15},
    {16'h8000, 4'd0},
    {16'h7000, 4'd0},
    {16'hF0F0, 4'd7},
    {16'hCAFE, 4'd3},
    {16'h5555, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0, last = 1'b0, mod_act = 1'b1;
  logic [15:0] pat = '0;
  logic [3:0]  len = '0;
  logic        en_all = 1'b0, en_last = 1'b0;
  logic        guard, err;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_guard_gen i_tx_guard_gen (
    .clk_i(clk), .rst_ni(rst_n), .cyc_strobe_i(strobe), .last_cyc_i(last),
    .mod_active_i(mod_act), .pattern_i(pat), .len_i(len), .en_all_i(en_all),
    .en_last_i(en_last), .guard_o(guard), .cfg_err_o(err)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic [15:0] p, input logic [3:0] l,
                         input logic ea, input logic el);
    @(negedge clk);
    pat = p; len = l; en_all = ea; en_last = el;
    @(negedge clk);
    @(negedge clk);
  endtask

  // call at a falling edge; returns at the falling edge of output cycle 0
  task automatic pulse(input logic lc);
    strobe = 1'b1; last = lc;
    @(negedge clk);
    strobe = 1'b0; last = 1'b0;
  endtask

  task automatic expect_seq(input logic [15:0] p, input int l, input string req);
    for (int i = 0; i <= l; i++) begin
      chk(guard, p[15-i], req);
      @(negedge clk);
    end
    chk(guard, 1'b0, req);
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(guard, 1'b0, req);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 2);
    // R1 reset state
    chk(guard, 1'b0, "R1");
    chk(err, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulse(1'b1);
    expect_quiet(3, "R1 enables reset to 0");

    // R2 R3 R5 vector walk, all-cycles mode
    for (int v = 0; v < N_VEC; v++) begin
      set_cfg(VEC[v][19:4], VEC[v][3:0], 1'b1, 1'b0);
      pulse(v[0]);
      expect_seq(VEC[v][19:4], int'(VEC[v][3:0]), "R2/R3/R5");
      @(negedge clk);
    end

    // R4 low bits ignored
    set_cfg(16'hA000, 4'd3, 1'b1, 1'b0);
    pulse(1'b0);
    expect_seq(16'hA000, 3, "R4 base");
    set_cfg(16'hAFFF, 4'd3, 1'b1, 1'b0);
    pulse(1'b0);
    expect_seq(16'hA000, 3, "R4 low bits set");

    // R6 final-cycle mode
    set_cfg(16'hFFFF, 4'd4, 1'b0, 1'b1);
    pulse(1'b0);
    expect_quiet(6, "R6 not last");
    pulse(1'b1);
    expect_seq(16'hFFFF, 4, "R6 last");

    // R8 no modulation
    set_cfg(16'hFFFF, 4'd4, 1'b1, 1'b0);
    mod_act = 1'b0;
    pulse(1'b1);
    expect_quiet(6, "R8");
    mod_act = 1'b1;

    // R7 both enables
    set_cfg(16'hFFFF, 4'd4, 1'b1, 1'b1);
    chk(err, 1'b1, "R7 error flag");
    pulse(1'b1);
    expect_quiet(6, "R7 guard low");
    set_cfg(16'hFFFF, 4'd4, 1'b1, 1'b0);
    chk(err, 1'b0, "R7 error clears");

    // R9 restart mid-sequence
    set_cfg(16'hB3C5, 4'd15, 1'b1, 1'b0);
    pulse(1'b0);
    chk(guard, 1'b1, "R9 b0");
    @(negedge clk); chk(guard, 1'b0, "R9 b1");
    @(negedge clk); chk(guard, 1'b1, "R9 b2");
    pulse(1'b0);
    expect_seq(16'hB3C5, 15, "R9 restart");

    // R10 pattern and length change during sequence
    set_cfg(16'hF00F, 4'd7, 1'b1, 1'b0);
    pulse(1'b0);
    pat = 16'h0FF0; len = 4'd15;
    expect_seq(16'hF00F, 7, "R10 captured");
    @(negedge clk);
    pulse(1'b0);
    expect_seq(16'h0FF0, 15, "R10 new cfg");

    // R11 disable mid-sequence
    set_cfg(16'hFFFF, 4'd15, 1'b1, 1'b0);
    pulse(1'b0);
    chk(guard, 1'b1, "R11 running");
    en_all = 1'b0;
    @(negedge clk);
    expect_quiet(4, "R11 forced low");
    en_all = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_quiet(3, "R11 sequence ended");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule